// File: doc/BRIEF.md
# PCS Management Register File

This block holds the management registers of a 1 Gb/s Ethernet physical coding sublayer. A host reaches them through a simple parallel read/write port. Each access carries a 5-bit MMD device number and a 16-bit register offset. Two vendor device numbers are decoded. The "global" device holds one register, and its bit 0 opens or closes the second device. The "link" device holds control, advertisement, partner ability, digital control, negotiation control and negotiation status.

The stored fields drive the datapath directly:
- negotiation enable;
- a one-cycle restart pulse;
- transmit-to-receive loopback;
- SGMII PHY mode;
- the PCS mode;
- the SGMII side select;
- a maskable completion interrupt.

An external negotiation engine reports completion with a one-cycle strobe. With the strobe it gives the resolved link, speed, duplex and the partner's ability word. The block latches all of these together with a sticky completion flag. Software clears the flag by writing zero to the status register.

Top module: `pcs_mgmt_regs`

## Requirements
- R1: After reset every register reads 0, with one exception: the global device (30) register at offset 0x0009 reads 0x0001. After reset all control outputs are low except `mii_mmd_en`, which is high.
- R2: A read returns its data one cycle later, with `reg_rvalid` high for that cycle. When `reg_rvalid` is low, `reg_rdata` is 0. The global register is at device 30, offset 0x0009, and bit 0 is the link-device enable. The link device is 31, with these offsets:
  - control at 0x0000;
  - advertisement at 0x0004;
  - partner ability at 0x0005;
  - digital control at 0x8000;
  - negotiation control at 0x8001;
  - negotiation status at 0x8002.
- R3: In link control, bit 12 drives `an_enable` and bit 14 drives `loopback_en`. All other bits of link control read 0.
- R4: Writing link control with bit 9 set makes `an_restart` high for exactly the cycle after the write. Bit 9 always reads back 0.
- R5: In advertisement, bits 8:5 are writable: bit 5 is full duplex, bit 6 is half duplex and bits 8:7 are pause. All other bits read 0.
- R6: Digital control bit 0 drives `sgmii_phy_mode`. In negotiation control:
  - bit 0 is the interrupt enable;
  - bits 2:1 drive `pcs_mode` (0 = 1000BASE-X, 2 = SGMII);
  - bit 3 drives `sgmii_phy_side` (1 = PHY side, 0 = MAC side);
  - all other bits read 0.
- R7: On the edge where `an_done` is high, the status register loads these fields:
  - bit 0 = 1 (completion flag);
  - bit 1 = duplex;
  - bits 3:2 = speed code (0 = 10, 1 = 100, 2 = 1000 Mb/s);
  - bit 4 = link.
  On the same edge, partner ability loads `an_lp_word`.
- R8: A status write with bit 0 = 0 clears the completion flag and leaves the other fields unchanged. A status write with bit 0 = 1 has no effect. If `an_done` and a clearing write arrive in the same cycle, the flag stays set.
- R9: `an_irq` is the registered AND of the completion flag and the interrupt enable. It rises one cycle after the flag sets, stays high until the flag is cleared, and stays low while the enable is 0.
- R10: Partner ability is read-only from the port.
- R11: Reads of unmapped offsets and of other device numbers return 0. Writes to them change no register.
- R12: While the global enable bit is 0, link-device reads return 0 and link-device writes are ignored. The global register stays accessible throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_dev | input | 5 | MMD device number |
| reg_off | input | 16 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| an_done | input | 1 | Negotiation-complete strobe |
| an_link | input | 1 | Resolved link state |
| an_speed | input | 2 | Resolved speed code |
| an_full_dup | input | 1 | Resolved full duplex |
| an_lp_word | input | 16 | Partner ability word |
| mii_mmd_en | output | 1 | Link device enabled |
| an_enable | output | 1 | Negotiation enable |
| an_restart | output | 1 | One-cycle restart pulse |
| loopback_en | output | 1 | Transmit-to-receive loopback |
| sgmii_phy_mode | output | 1 | SGMII PHY mode |
| pcs_mode | output | 2 | PCS mode select |
| sgmii_phy_side | output | 1 | SGMII side select |
| an_irq | output | 1 | Completion interrupt |

## Verification
Writes of all-ones, all-zeros and single-field patterns are read back from each register. This separates writable bits from reserved bits and reveals a shifted field.

Completion events are sent with two different speed, duplex and link mixes. This confirms that each field lands in its own bit. Further directed sequences cover:
- a clearing write in the same cycle as an event, which tells whether set or clear has priority;
- a write of 1 to the flag, which must leave it set;
- toggling the interrupt enable, which separates masking from clearing;
- accesses to near-miss offsets, to a foreign device number and to a closed link device, which tell a full decode from a partial one.

// File: rtl/pcs_mgmt_pkg.sv
package pcs_mgmt_pkg;

    localparam int REG_W = 16;

    localparam logic [15:0] OFF_GLB_CTL   = 16'h0009;
    localparam logic [15:0] OFF_LNK_CTL   = 16'h0000;
    localparam logic [15:0] OFF_ADV       = 16'h0004;
    localparam logic [15:0] OFF_LPA       = 16'h0005;
    localparam logic [15:0] OFF_DIG1      = 16'h8000;
    localparam logic [15:0] OFF_ANCTL     = 16'h8001;
    localparam logic [15:0] OFF_ANSTAT    = 16'h8002;

    localparam int BIT_LOOPBACK = 14;
    localparam int BIT_AN_EN    = 12;
    localparam int BIT_RESTART  = 9;
    localparam int ABIL_LO      = 5;
    localparam int ABIL_HI      = 8;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_GLB_CTL,
        SEL_LNK_CTL,
        SEL_ADV,
        SEL_LPA,
        SEL_DIG1,
        SEL_ANCTL,
        SEL_ANSTAT
    } reg_sel_e;

    typedef struct packed {
        logic       link;
        logic [1:0] speed;
        logic       full_dup;
    } an_result_t;

    typedef struct packed {
        logic                     mmd_en;
        logic                     an_en;
        logic                     loopback;
        logic                     phy_mode;
        logic                     irq_en;
        logic [1:0]               pcs_mode;
        logic                     phy_side;
        logic [ABIL_HI-ABIL_LO:0] adv;
    } ctrl_cfg_t;

    function automatic logic [REG_W-1:0] status_word(input logic flag, input an_result_t r);
        return {{(REG_W-5){1'b0}}, r.link, r.speed, r.full_dup, flag};
    endfunction

    function automatic logic [REG_W-1:0] link_ctl_word(input ctrl_cfg_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[BIT_LOOPBACK] = c.loopback;
        w[BIT_AN_EN]    = c.an_en;
        return w;
    endfunction

endpackage

// File: rtl/pcs_mgmt_decode.sv
module pcs_mgmt_decode
    import pcs_mgmt_pkg::*;
#(
    parameter int          DEV_W    = 5,
    parameter int          OFF_W    = 16,
    parameter int unsigned CTRL_DEV = 30,
    parameter int unsigned MII_DEV  = 31
) (
    input  logic [DEV_W-1:0] dev,
    input  logic [OFF_W-1:0] off,
    input  logic             mii_en,
    output reg_sel_e         sel
);

    localparam logic [DEV_W-1:0] GLB_DEV = DEV_W'(CTRL_DEV);
    localparam logic [DEV_W-1:0] LNK_DEV = DEV_W'(MII_DEV);

    always_comb begin
        sel = SEL_NONE;
        if (dev == GLB_DEV) begin
            if (off == OFF_W'(OFF_GLB_CTL)) sel = SEL_GLB_CTL;
        end else if (dev == LNK_DEV && mii_en) begin
            case (off)
                OFF_W'(OFF_LNK_CTL): sel = SEL_LNK_CTL;
                OFF_W'(OFF_ADV):     sel = SEL_ADV;
                OFF_W'(OFF_LPA):     sel = SEL_LPA;
                OFF_W'(OFF_DIG1):    sel = SEL_DIG1;
                OFF_W'(OFF_ANCTL):   sel = SEL_ANCTL;
                OFF_W'(OFF_ANSTAT):  sel = SEL_ANSTAT;
                default:             sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/pcs_mgmt_ctrl.sv
module pcs_mgmt_ctrl
    import pcs_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  reg_sel_e         sel,
    input  logic [REG_W-1:0] wdata,
    output ctrl_cfg_t        cfg,
    output logic             restart
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg        <= '0;
            cfg.mmd_en <= 1'b1;
            restart    <= 1'b0;
        end else begin
            restart <= 1'b0;
            if (wr) begin
                case (sel)
                    SEL_GLB_CTL: cfg.mmd_en <= wdata[0];
                    SEL_LNK_CTL: begin
                        cfg.an_en    <= wdata[BIT_AN_EN];
                        cfg.loopback <= wdata[BIT_LOOPBACK];
                        restart      <= wdata[BIT_RESTART];
                    end
                    SEL_ADV:  cfg.adv <= wdata[ABIL_HI:ABIL_LO];
                    SEL_DIG1: cfg.phy_mode <= wdata[0];
                    SEL_ANCTL: begin
                        cfg.irq_en   <= wdata[0];
                        cfg.pcs_mode <= wdata[2:1];
                        cfg.phy_side <= wdata[3];
                    end
                    default: ;
                endcase
            end
        end
    end

    // R4: a restart pulse only follows a link-control write carrying the restart bit
    assert_restart_src_R4: assert property (@(posedge clk) disable iff (rst)
        restart |-> $past(wr && sel == SEL_LNK_CTL && wdata[BIT_RESTART]));

endmodule

// File: rtl/pcs_mgmt_anstat.sv
module pcs_mgmt_anstat
    import pcs_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  reg_sel_e         sel,
    input  logic [REG_W-1:0] wdata,
    input  logic             an_done,
    input  an_result_t       an_res,
    input  logic [REG_W-1:0] lp_word,
    input  logic             irq_en,
    output logic             flag,
    output an_result_t       res_q,
    output logic [REG_W-1:0] lp_q,
    output logic             irq
);

    logic clr_req;
    assign clr_req = wr && (sel == SEL_ANSTAT) && !wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            res_q <= '0;
            lp_q  <= '0;
            irq   <= 1'b0;
        end else begin
            if (an_done) begin
                flag  <= 1'b1;
                res_q <= an_res;
                lp_q  <= lp_word;
            end else if (clr_req) begin
                flag <= 1'b0;
            end
            irq <= flag & irq_en;
        end
    end

    // R8: completion event wins over a same-cycle clear
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        an_done |=> flag);

    // R8: clearing write without an event drops the flag
    assert_clear_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !an_done) |=> !flag);

    // R9: interrupt stays low while masked
    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(irq_en) |-> !irq);

    // R10: partner word only changes on a completion event
    assert_lp_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(an_done) && !$past(rst)) |-> $stable(lp_q));

endmodule

// File: rtl/pcs_mgmt_regs.sv
module pcs_mgmt_regs
    import pcs_mgmt_pkg::*;
#(
    parameter int          DEV_W    = 5,
    parameter int          OFF_W    = 16,
    parameter int unsigned CTRL_DEV = 30,
    parameter int unsigned MII_DEV  = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [DEV_W-1:0] reg_dev,
    input  logic [OFF_W-1:0] reg_off,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    output logic             reg_rvalid,
    input  logic             an_done,
    input  logic             an_link,
    input  logic [1:0]       an_speed,
    input  logic             an_full_dup,
    input  logic [15:0]      an_lp_word,
    output logic             mii_mmd_en,
    output logic             an_enable,
    output logic             an_restart,
    output logic             loopback_en,
    output logic             sgmii_phy_mode,
    output logic [1:0]       pcs_mode,
    output logic             sgmii_phy_side,
    output logic             an_irq
);

    reg_sel_e         sel;
    ctrl_cfg_t        cfg;
    logic             flag;
    an_result_t       res_q;
    an_result_t       res_in;
    logic [REG_W-1:0] lp_q;
    logic [REG_W-1:0] rd_word;
    logic [REG_W-1:0] rdata_q;
    logic             rvalid_q;

    assign res_in = '{link: an_link, speed: an_speed, full_dup: an_full_dup};

    pcs_mgmt_decode #(
        .DEV_W(DEV_W), .OFF_W(OFF_W), .CTRL_DEV(CTRL_DEV), .MII_DEV(MII_DEV)
    ) u_decode (
        .dev(reg_dev), .off(reg_off), .mii_en(cfg.mmd_en), .sel(sel)
    );

    pcs_mgmt_ctrl u_ctrl (
        .clk(clk), .rst(rst), .wr(reg_wr), .sel(sel), .wdata(reg_wdata),
        .cfg(cfg), .restart(an_restart)
    );

    pcs_mgmt_anstat u_anstat (
        .clk(clk), .rst(rst), .wr(reg_wr), .sel(sel), .wdata(reg_wdata),
        .an_done(an_done), .an_res(res_in), .lp_word(an_lp_word),
        .irq_en(cfg.irq_en), .flag(flag), .res_q(res_q), .lp_q(lp_q), .irq(an_irq)
    );

    always_comb begin
        case (sel)
            SEL_GLB_CTL: rd_word = REG_W'(cfg.mmd_en);
            SEL_LNK_CTL: rd_word = link_ctl_word(cfg);
            SEL_ADV:     rd_word = REG_W'({cfg.adv, {ABIL_LO{1'b0}}});
            SEL_LPA:     rd_word = lp_q;
            SEL_DIG1:    rd_word = REG_W'(cfg.phy_mode);
            SEL_ANCTL:   rd_word = REG_W'({cfg.phy_side, cfg.pcs_mode, cfg.irq_en});
            SEL_ANSTAT:  rd_word = status_word(flag, res_q);
            default:     rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= reg_rd;
            rdata_q  <= reg_rd ? rd_word : '0;
        end
    end

    assign reg_rdata      = rdata_q;
    assign reg_rvalid     = rvalid_q;
    assign mii_mmd_en     = cfg.mmd_en;
    assign an_enable      = cfg.an_en;
    assign loopback_en    = cfg.loopback;
    assign sgmii_phy_mode = cfg.phy_mode;
    assign pcs_mode       = cfg.pcs_mode;
    assign sgmii_phy_side = cfg.phy_side;

    // R2: data bus idles at zero outside a read response
    assert_rdata_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !reg_rvalid |-> reg_rdata == '0);

    // R2: valid strobe follows a read request by one cycle
    assert_rvalid_lat_R2: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> reg_rvalid);

endmodule

// File: tb/test_pcs_mgmt_regs.sv
module test_pcs_mgmt_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [4:0]  reg_dev = '0;
    logic [15:0] reg_off = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        reg_rvalid;
    logic        an_done = 1'b0;
    logic        an_link = 1'b0;
    logic [1:0]  an_speed = '0;
    logic        an_full_dup = 1'b0;
    logic [15:0] an_lp_word = '0;
    logic        mii_mmd_en, an_enable, an_restart, loopback_en;
    logic        sgmii_phy_mode, sgmii_phy_side, an_irq;
    logic [1:0]  pcs_mode;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pcs_mgmt_regs i_pcs_mgmt_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_dev(reg_dev),
        .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .an_done(an_done), .an_link(an_link),
        .an_speed(an_speed), .an_full_dup(an_full_dup), .an_lp_word(an_lp_word),
        .mii_mmd_en(mii_mmd_en), .an_enable(an_enable), .an_restart(an_restart),
        .loopback_en(loopback_en), .sgmii_phy_mode(sgmii_phy_mode),
        .pcs_mode(pcs_mode), .sgmii_phy_side(sgmii_phy_side), .an_irq(an_irq)
    );

    // {device, offset, write data, expected read-back}
    localparam int NV = 10;
    localparam logic [52:0] VEC [NV] = '{
        {5'd31, 16'h0000, 16'h5200, 16'h5000},  // R3 R4 restart reads 0
        {5'd31, 16'h0000, 16'hFFFF, 16'h5000},  // R3 reserved bits 0
        {5'd31, 16'h0004, 16'h01E0, 16'h01E0},  // R5 all ability bits
        {5'd31, 16'h0004, 16'hFE1F, 16'h0000},  // R5 reserved only
        {5'd31, 16'h8000, 16'hFFFF, 16'h0001},  // R6 digital control
        {5'd31, 16'h8001, 16'h000D, 16'h000D},  // R6 en, SGMII, PHY side
        {5'd31, 16'h8001, 16'hFFF2, 16'h0002},  // R6 reserved masked
        {5'd30, 16'h0009, 16'hFFFF, 16'h0001},  // R2 global register
        {5'd31, 16'h0005, 16'hFFFF, 16'h0000},  // R10 read-only
        {5'd31, 16'h8002, 16'h0000, 16'h0000}   // R8 clear when idle
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [4:0] dev, input logic [15:0] off, input logic [15:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_dev = dev; reg_off = off; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_read(input logic [4:0] dev, input logic [15:0] off, output logic [15:0] data);
        @(negedge clk);
        reg_rd = 1'b1; reg_dev = dev; reg_off = off;
        @(posedge clk);
        #1;
        data = reg_rdata;
        chk("R2 rvalid", {15'b0, reg_rvalid}, 16'h0001);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 mii_mmd_en", {15'b0, mii_mmd_en}, 16'h0001);
        chk("R1 outputs", {9'b0, an_enable, an_restart, loopback_en, sgmii_phy_mode,
                           pcs_mode, sgmii_phy_side}, 16'h0000);
        chk("R1 an_irq", {15'b0, an_irq}, 16'h0000);
        chk("R2 idle rdata", reg_rdata, 16'h0000);
        do_read(5'd30, 16'h0009, rd); chk("R1 global reset", rd, 16'h0001);
        do_read(5'd31, 16'h0000, rd); chk("R1 link ctl reset", rd, 16'h0000);
        do_read(5'd31, 16'h8001, rd); chk("R1 anctl reset", rd, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][52:48], VEC[i][47:32], VEC[i][31:16]);
            do_read(VEC[i][52:48], VEC[i][47:32], rd);
            chk($sformatf("table entry %0d", i), rd, VEC[i][15:0]);
        end

        // R3 R6 outputs after the table
        chk("R3 an_enable", {15'b0, an_enable}, 16'h0001);
        chk("R3 loopback_en", {15'b0, loopback_en}, 16'h0001);
        chk("R6 phy_mode", {15'b0, sgmii_phy_mode}, 16'h0001);
        chk("R6 pcs_mode", {14'b0, pcs_mode}, 16'h0001);

        // R4 restart pulse timing
        @(negedge clk);
        reg_wr = 1'b1; reg_dev = 5'd31; reg_off = 16'h0000; reg_wdata = 16'h1200;
        @(posedge clk); #1;
        chk("R4 restart high", {15'b0, an_restart}, 16'h0001);
        @(negedge clk);
        reg_wr = 1'b0;
        @(posedge clk); #1;
        chk("R4 restart single", {15'b0, an_restart}, 16'h0000);
        chk("R3 loopback off", {15'b0, loopback_en}, 16'h0000);

        // R6 SGMII, PHY side, interrupt enabled
        do_write(5'd31, 16'h8001, 16'h000D);
        chk("R6 pcs_mode sgmii", {14'b0, pcs_mode}, 16'h0002);
        chk("R6 phy side", {15'b0, sgmii_phy_side}, 16'h0001);

        // R7 R9 completion event
        @(negedge clk);
        an_done = 1'b1; an_link = 1'b1; an_speed = 2'd2; an_full_dup = 1'b1;
        an_lp_word = 16'h01A0;
        @(posedge clk); #1;
        chk("R9 irq registered", {15'b0, an_irq}, 16'h0000);
        @(negedge clk);
        an_done = 1'b0;
        @(posedge clk); #1;
        chk("R9 irq raised", {15'b0, an_irq}, 16'h0001);
        do_read(5'd31, 16'h8002, rd); chk("R7 status", rd, 16'h001B);
        do_read(5'd31, 16'h0005, rd); chk("R7 partner", rd, 16'h01A0);

        // R8 writing 1 keeps flag
        do_write(5'd31, 16'h8002, 16'h0001);
        do_read(5'd31, 16'h8002, rd); chk("R8 write one", rd, 16'h001B);
        chk("R9 irq held", {15'b0, an_irq}, 16'h0001);

        // R10 partner write ignored
        do_write(5'd31, 16'h0005, 16'h0000);
        do_read(5'd31, 16'h0005, rd); chk("R10 partner ro", rd, 16'h01A0);

        // R8 clear
        do_write(5'd31, 16'h8002, 16'h0000);
        do_read(5'd31, 16'h8002, rd); chk("R8 cleared", rd, 16'h001A);
        chk("R9 irq cleared", {15'b0, an_irq}, 16'h0000);

        // R8 set wins over same-cycle clear
        @(negedge clk);
        an_done = 1'b1; an_link = 1'b0; an_speed = 2'd1; an_full_dup = 1'b0;
        an_lp_word = 16'h0040;
        reg_wr = 1'b1; reg_dev = 5'd31; reg_off = 16'h8002; reg_wdata = 16'h0000;
        @(negedge clk);
        an_done = 1'b0; reg_wr = 1'b0;
        do_read(5'd31, 16'h8002, rd); chk("R8 set wins", rd, 16'h0005);
        do_read(5'd31, 16'h0005, rd); chk("R7 partner reload", rd, 16'h0040);

        // R9 masking
        do_write(5'd31, 16'h8001, 16'h000C);
        repeat (2) @(posedge clk);
        #1;
        chk("R9 masked", {15'b0, an_irq}, 16'h0000);
        do_write(5'd31, 16'h8001, 16'h000D);
        @(posedge clk); #1;
        chk("R9 unmasked", {15'b0, an_irq}, 16'h0001);

        // R11 unmapped accesses
        do_write(5'd31, 16'h0014, 16'h01E0);
        do_write(5'd29, 16'h0004, 16'h01E0);
        do_write(5'd31, 16'h8003, 16'hFFFF);
        do_read(5'd31, 16'h0004, rd); chk("R11 adv untouched", rd, 16'h0000);
        do_read(5'd31, 16'h8001, rd); chk("R11 anctl untouched", rd, 16'h000D);
        do_read(5'd31, 16'h0014, rd); chk("R11 unmapped read", rd, 16'h0000);
        do_read(5'd29, 16'h0004, rd); chk("R11 foreign dev", rd, 16'h0000);
        do_read(5'd31, 16'h8003, rd); chk("R11 near miss", rd, 16'h0000);

        // R12 link device gating
        do_write(5'd31, 16'h0004, 16'h0060);
        do_write(5'd30, 16'h0009, 16'h0000);
        chk("R12 enable low", {15'b0, mii_mmd_en}, 16'h0000);
        do_read(5'd31, 16'h0004, rd); chk("R12 closed read", rd, 16'h0000);
        do_write(5'd31, 16'h0004, 16'h0180);
        do_read(5'd30, 16'h0009, rd); chk("R12 global readable", rd, 16'h0000);
        do_write(5'd30, 16'h0009, 16'h0001);
        do_read(5'd31, 16'h0004, rd); chk("R12 write ignored", rd, 16'h0060);

        @(negedge clk);
        chk("R2 idle after reads", reg_rdata, 16'h0000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule